// File: doc/BRIEF.md
# Smart Card Clock, ETU Timer and Response Watchdog

This block supplies the timing for one ISO 7816 smart card port. It divides the system clock down to the card clock, using one of seven divisors picked by a 3-bit code. It counts card-clock periods to mark each elementary time unit (ETU) with a one-cycle tick. It also runs a watchdog that flags a card that has stopped answering.

The receiver sends a one-cycle pulse each time it samples the parity bit of an incoming character. The watchdog then waits half a character, taken as five ETUs. After that it counts ETUs in a saturating up-counter, which is 24 bits wide by default. Two timeout registers are held at all times, and a select bit picks which one is compared against the count. Software can therefore switch between a short and a long wait without rewriting a value. When the count goes above the selected timeout, a sticky interrupt is raised. Software clears it by writing a one to a control bit.

Software programs the block through a simple write port. The port has a control word at address 0, the clock select at address 1, the baud divisor at address 2, and the two timeouts at addresses 3 and 4. Control bit 0 selects the timeout (0 = first, 1 = second). Control bit 1 clears the interrupt. Control bit 2 performs a software reset.

Top module: `card_timer`

## Requirements
- R1: The clock select code 0..6 divides the system clock by 2, 3, 4, 6, 8, 12 and 16 in that order, and code 7 also divides by 16. The card clock is high for floor(N/2) system cycles and low for the remaining cycles of each period.
- R2: A new clock select takes effect only at the end of the current card-clock period. No high or low phase is ever shorter or longer than the old or the new divisor would give.
- R3: The ETU tick is a one-system-cycle pulse that repeats every N×B system cycles, where B is the baud divisor in card-clock periods. B=0 behaves as 2^BAUD_W.
- R4: The watchdog is idle after reset and does not count until the first parity pulse. After a parity pulse the first five ETU ticks only measure the half character, and each later tick adds one to the count.
- R5: The interrupt rises within two cycles of the count going above the selected timeout. Equivalently, after a parity pulse with timeout T, it is low through ETU tick T+5 and high after ETU tick T+6.
- R6: The watchdog count saturates at its all-ones value and never wraps to zero.
- R7: The interrupt is sticky. It falls only when control bit 1 is written as 1 while the count does not exceed the selected timeout. A new parity pulse clears the count and restarts the half-character delay.
- R8: Writing the timeout select bit switches the comparison to the other timeout register at once, with no reload or restart of the count.
- R9: Writing control bit 2 as 1 performs a software reset. It returns the clock select to code 0 (divide by 2) and the baud divisor to 372. It also idles the watchdog and clears the interrupt, while both timeout registers keep their values.
- R10: After a hardware reset the card clock divides by 2, the baud divisor is 372 (an ETU tick every 744 system cycles), the interrupt is low, and both timeouts are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 clock select, 2 baud, 3 timeout 0, 4 timeout 1) |
| reg_wdata | input | REG_W | Register write data |
| parity_seen | input | 1 | One-cycle pulse from the receiver at the parity bit of a character |
| card_clk | output | 1 | Divided card clock |
| etu_tick | output | 1 | One-cycle pulse per elementary time unit |
| wdog_irq | output | 1 | Sticky watchdog interrupt |

## Verification
The bench builds the block with a 6-bit watchdog counter, leaving the baud width at 12 bits and the half-character delay at five ETUs. With a 6-bit counter, saturation at 63 is reached in a few hundred cycles, which lets the bench show the difference between saturating and wrapping through the interrupt port. A small programmed baud divisor keeps each ETU to eight system cycles, so many watchdog thresholds can be tried. The default divisor of 372 is still measured directly after hardware and software resets.

// File: rtl/card_timer_pkg.sv
// Package: shared constants, register addresses, divisor decode and
// watchdog states for the smart card timing block.
package card_timer_pkg;

    localparam int DIV_W = 5;  // wide enough for the largest card-clock divisor (16)

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_CLKSEL = 3'd1,
        A_BAUD   = 3'd2,
        A_TMO0   = 3'd3,
        A_TMO1   = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_HALF = 2'd1,
        WD_RUN  = 2'd2
    } wd_state_e;

    // Map the 3-bit select code to a system-clock divisor.
    function automatic logic [DIV_W-1:0] clk_divisor(input logic [2:0] sel);
        case (sel)
            3'd0:    return DIV_W'(2);
            3'd1:    return DIV_W'(3);
            3'd2:    return DIV_W'(4);
            3'd3:    return DIV_W'(6);
            3'd4:    return DIV_W'(8);
            3'd5:    return DIV_W'(12);
            default: return DIV_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/card_clk_gen.sv
// card_clk_gen: divides the system clock by a selectable integer.
// Assumes: sel is a registered value. A new divisor is adopted only
// when the current period wraps, so the output never has a short or
// long phase. The output is high for floor(N/2) cycles of each period.
module card_clk_gen
    import card_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       card_clk,
    output logic       cclk_edge
);

    logic [DIV_W-1:0] cnt, div_q, nxt_cnt, nxt_div;
    logic             wrap;
    logic             card_clk_q;

    // Work out the period wrap and the next count/divisor.
    always_comb begin
        wrap    = (cnt == div_q - DIV_W'(1));
        nxt_cnt = wrap ? '0 : cnt + DIV_W'(1);
        nxt_div = wrap ? clk_divisor(sel) : div_q;
    end

    // Advance the phase counter and register the clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            div_q      <= DIV_W'(2);
            card_clk_q <= 1'b0;
        end else begin
            cnt        <= nxt_cnt;
            div_q      <= nxt_div;
            card_clk_q <= (nxt_cnt < (nxt_div >> 1));
        end
    end

    assign card_clk  = card_clk_q;
    assign cclk_edge = wrap;

    // R1: the card clock is high in the cycle after each period wrap
    p_rise_after_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> card_clk);

    // R2: the divisor only changes at a period boundary
    p_div_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(div_q));

endmodule

// File: rtl/etu_gen.sv
// etu_gen: counts card-clock periods and emits a one-cycle tick at
// the end of each elementary time unit.
// Assumes: cclk_edge pulses once per card-clock period, at most every
// other cycle. A baud divisor of 0 gives a period of 2^BAUD_W.
module etu_gen #(
    parameter int BAUD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cclk_edge,
    input  logic [BAUD_W-1:0] baud_div,
    output logic              etu_tick
);

    logic [BAUD_W-1:0] cnt;
    logic              tick_q;

    // Count card-clock periods and pulse the tick on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (cclk_edge) begin
                if (cnt >= baud_div - BAUD_W'(1)) begin
                    cnt    <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt <= cnt + BAUD_W'(1);
                end
            end
        end
    end

    assign etu_tick = tick_q;

    // R3: a tick only follows a card-clock period boundary
    p_tick_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        etu_tick |-> $past(cclk_edge));

    // R3: a tick lasts a single system cycle
    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        etu_tick |=> !etu_tick);

endmodule

// File: rtl/card_wdog.sv
// card_wdog: unresponsive-card watchdog. A parity pulse clears the
// count and starts a half-character delay of HALF_ETUS ticks. After
// the delay the counter counts ETU ticks and saturates. A sticky
// interrupt rises when the count exceeds the selected timeout.
// Assumes: etu_tick and parity_seen are single-cycle pulses. If
// parity_seen and etu_tick arrive together, parity_seen wins.
module card_wdog
    import card_timer_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int HALF_ETUS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             etu_tick,
    input  logic             parity_seen,
    input  logic [CNT_W-1:0] tmo_a,
    input  logic [CNT_W-1:0] tmo_b,
    input  logic             tmo_sel,
    input  logic             irq_clr,
    output logic             irq
);

    localparam int HALF_W = $clog2(HALF_ETUS + 1);

    wd_state_e         state;
    logic [HALF_W-1:0] half_cnt;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  active_tmo;
    logic              over;
    logic              irq_q;

    // Pick the live timeout and decide whether it has been exceeded.
    always_comb begin
        active_tmo = tmo_sel ? tmo_b : tmo_a;
        over       = (state == WD_RUN) && (count > active_tmo);
    end

    // Sequence the idle/half-delay/run phases and the saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state    <= WD_IDLE;
            half_cnt <= '0;
            count    <= '0;
        end else if (parity_seen) begin
            state    <= WD_HALF;
            half_cnt <= '0;
            count    <= '0;
        end else begin
            case (state)
                WD_HALF: if (etu_tick) begin
                    if (half_cnt == HALF_W'(HALF_ETUS - 1)) state <= WD_RUN;
                    else half_cnt <= half_cnt + HALF_W'(1);
                end
                WD_RUN: if (etu_tick && count != '1) count <= count + CNT_W'(1);
                default: ;
            endcase
        end
    end

    // Hold the interrupt until a clear arrives with no timeout pending.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) irq_q <= 1'b0;
        else if (over)          irq_q <= 1'b1;
        else if (irq_clr)       irq_q <= 1'b0;
    end

    assign irq = irq_q;

    // R4: once running, the count moves only on an ETU tick
    p_step_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && !etu_tick && !parity_seen && !soft_rst) |=> $stable(count));

    // R5: the interrupt only rises while the counter is running
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state == WD_RUN));

    // R6: a full counter stays full
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '1 && !parity_seen && !soft_rst) |=> (count == '1));

    // R7: the interrupt is sticky without a clear
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr && !soft_rst) |=> irq);

    // R7: a parity pulse restarts the half-character delay with a zero count
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_seen && !soft_rst) |=> (state == WD_HALF && count == '0));

endmodule

// File: rtl/card_timer.sv
// card_timer: top level of the smart card timing block. Holds the
// write-only configuration registers and connects the card-clock
// divider, the ETU generator and the response watchdog.
// Assumes: one register write per cycle; upper data bits beyond a
// field's width are ignored.
module card_timer
    import card_timer_pkg::*;
#(
    parameter int BAUD_W     = 12,
    parameter int WDOG_W     = 24,
    parameter int HALF_ETUS  = 5,
    parameter int BAUD_RESET = 372,
    parameter int REG_W      = (WDOG_W > BAUD_W) ? WDOG_W : BAUD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             parity_seen,
    output logic             card_clk,
    output logic             etu_tick,
    output logic             wdog_irq
);

    logic [2:0]        clk_sel;
    logic [BAUD_W-1:0] baud;
    logic [WDOG_W-1:0] tmo_a, tmo_b;
    logic              tmo_sel;
    logic              ctrl_wr, soft_rst, irq_clr;
    logic              cclk_edge;

    // Decode the control-word strobes.
    always_comb begin
        ctrl_wr  = reg_we && (reg_addr == A_CTRL);
        soft_rst = ctrl_wr && reg_wdata[2];
        irq_clr  = ctrl_wr && reg_wdata[1];
    end

    // Configuration registers with hardware and software reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel <= 3'd0;
            baud    <= BAUD_W'(BAUD_RESET);
            tmo_a   <= '1;
            tmo_b   <= '1;
            tmo_sel <= 1'b0;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    tmo_sel <= reg_wdata[0];
                    if (reg_wdata[2]) begin
                        clk_sel <= 3'd0;
                        baud    <= BAUD_W'(BAUD_RESET);
                    end
                end
                A_CLKSEL: clk_sel <= reg_wdata[2:0];
                A_BAUD:   baud    <= reg_wdata[BAUD_W-1:0];
                A_TMO0:   tmo_a   <= reg_wdata[WDOG_W-1:0];
                A_TMO1:   tmo_b   <= reg_wdata[WDOG_W-1:0];
                default: ;
            endcase
        end
    end

    card_clk_gen u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (clk_sel),
        .card_clk  (card_clk),
        .cclk_edge (cclk_edge)
    );

    etu_gen #(.BAUD_W(BAUD_W)) u_etu (
        .clk       (clk),
        .rst_n     (rst_n),
        .cclk_edge (cclk_edge),
        .baud_div  (baud),
        .etu_tick  (etu_tick)
    );

    card_wdog #(.CNT_W(WDOG_W), .HALF_ETUS(HALF_ETUS)) u_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .etu_tick    (etu_tick),
        .parity_seen (parity_seen),
        .tmo_a       (tmo_a),
        .tmo_b       (tmo_b),
        .tmo_sel     (tmo_sel),
        .irq_clr     (irq_clr),
        .irq         (wdog_irq)
    );

    // R9: a software reset leaves the interrupt low on the next cycle
    p_soft_clears_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !wdog_irq);

endmodule

// File: tb/card_timer_bench.sv
module card_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_W     = 6;
    localparam int BAUD_W     = 12;
    localparam int REG_W      = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic             parity_seen = 1'b0;
    logic             card_clk, etu_tick, wdog_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    card_timer #(.BAUD_W(BAUD_W), .WDOG_W(WDOG_W), .REG_W(REG_W)) u_card_timer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .parity_seen(parity_seen),
        .card_clk(card_clk), .etu_tick(etu_tick), .wdog_irq(wdog_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_div(input int sel);
        case (sel)
            0: return 2;  1: return 3;  2: return 4;  3: return 6;
            4: return 8;  5: return 12; default: return 16;
        endcase
    endfunction

    function automatic int exp_high(input int n);
        return n / 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands at the following posedge.
    task automatic wr(input logic [2:0] a, input int d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = REG_W'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic measure_clk(output int hi, output int lo);
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        hi = 0; lo = 0;
        while (card_clk) begin hi++; @(negedge clk); end
        while (!card_clk) begin lo++; @(negedge clk); end
    endtask

    task automatic wait_tick();
        while (!etu_tick) @(negedge clk);
    endtask

    task automatic tick_gap(output int gap);
        wait_tick();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!etu_tick);
    endtask

    task automatic check_clk(input int n, input string req);
        int hi, lo;
        measure_clk(hi, lo);
        chk(hi == exp_high(n), req, hi, exp_high(n));
        chk(lo == n - exp_high(n), req, lo, n - exp_high(n));
    endtask

    // One watchdog run: timeout t on register ts, pulse, then scan ticks.
    task automatic run_wd(input int t, input int ts);
        wr(ts ? 3'd4 : 3'd3, t);
        wr(3'd0, ts);
        @(negedge clk);
        wait_tick();
        parity_seen = 1'b1;
        @(negedge clk);
        parity_seen = 1'b0;
        wr(3'd0, ts | 2);                        // R7: clear after restart
        for (int k = 1; k <= t + 8; k++) begin
            @(negedge clk);
            wait_tick();
            repeat (3) @(negedge clk);
            chk(wdog_irq == (k >= t + 6), (k < t + 6) ? "R4/R7" : "R5",
                wdog_irq, (k >= t + 6));
        end
    endtask

    // Watchdog on the run itself.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed, gap, s, b;
        seed = $urandom(32'h5c7a11);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        chk(wdog_irq == 1'b0, "R10", wdog_irq, 0);
        check_clk(2, "R10");
        tick_gap(gap);
        chk(gap == 744, "R10", gap, 744);

        // R1: every select code
        for (int sel = 0; sel < 8; sel++) begin
            wr(3'd1, sel);
            repeat (40) @(negedge clk);
            check_clk(exp_div(sel), "R1");
        end

        // R3: random divisor and baud pairs
        for (int i = 0; i < 8; i++) begin
            s = $urandom % 7;
            b = 1 + ($urandom % 12);
            wr(3'd1, s);
            wr(3'd2, b);
            wait_tick(); @(negedge clk); wait_tick(); @(negedge clk);
            tick_gap(gap);
            chk(gap == exp_div(s) * b, "R3", gap, exp_div(s) * b);
        end

        // R2: switch /2 to /16 mid-period; every phase is 1 or 8 cycles
        wr(3'd1, 0);
        repeat (40) @(negedge clk);
        repeat ($urandom % 3) @(negedge clk);
        wr(3'd1, 6);
        begin
            int run; logic lvl; bit started; bit bad;
            run = 0; lvl = card_clk; started = 0; bad = 0;
            for (int c = 0; c < 80; c++) begin
                @(negedge clk);
                if (card_clk != lvl) begin
                    if (started && run != 1 && run != 8) bad = 1;
                    started = 1; run = 1; lvl = card_clk;
                end else run++;
            end
            chk(!bad, "R2", bad, 0);
        end

        // R4: idle until a parity pulse even with timeout 0
        wr(3'd1, 0);
        wr(3'd2, 4);
        wr(3'd3, 0);
        wr(3'd0, 0);
        repeat (20) begin @(negedge clk); wait_tick(); end
        repeat (3) @(negedge clk);
        chk(wdog_irq == 1'b0, "R4", wdog_irq, 0);

        // R5/R7: directed edges then random thresholds on both registers
        run_wd(0, 0);
        run_wd(3, 1);
        for (int i = 0; i < 4; i++) run_wd($urandom % 21, $urandom % 2);

        // R6/R8: saturation observed through a timeout switch
        wr(3'd3, 63);
        wr(3'd4, 50);
        wr(3'd0, 2);
        @(negedge clk);
        wait_tick();
        parity_seen = 1'b1;
        @(negedge clk);
        parity_seen = 1'b0;
        wr(3'd0, 2);
        repeat (75) begin @(negedge clk); wait_tick(); end
        repeat (3) @(negedge clk);
        chk(wdog_irq == 1'b0, "R6", wdog_irq, 0);
        wr(3'd0, 1);
        repeat (2) @(negedge clk);
        chk(wdog_irq == 1'b1, "R6/R8", wdog_irq, 1);
        wr(3'd0, 0);
        repeat (4) @(negedge clk);
        chk(wdog_irq == 1'b1, "R7", wdog_irq, 1);
        wr(3'd0, 2);
        repeat (2) @(negedge clk);
        chk(wdog_irq == 1'b0, "R7", wdog_irq, 0);

        // R9: software reset with irq pending and non-default timing
        run_wd(0, 0);
        wr(3'd1, 3);
        wr(3'd2, 7);
        wr(3'd0, 4);
        @(negedge clk);
        chk(wdog_irq == 1'b0, "R9", wdog_irq, 0);
        repeat (40) @(negedge clk);
        check_clk(2, "R9");
        tick_gap(gap);
        chk(gap == 744, "R9", gap, 744);
        wr(3'd2, 4);
        repeat (20) begin @(negedge clk); wait_tick(); end
        repeat (3) @(negedge clk);
        chk(wdog_irq == 1'b0, "R9", wdog_irq, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule